// File: doc/BRIEF.md
# Indexed Bit-Operation Sequencer

This block carries out the displaced-index bit-manipulation instruction group of an 8-bit processor. The front end has already consumed the prefix and opcode bytes. It hands over both index base registers, a flag that picks the alternate base, the signed 8-bit displacement, the final opcode byte and the current carry flag. The sequencer forms the effective address, reads one byte, and applies a rotate or shift, a single-bit test, a single-bit clear or a single-bit set.

For every group except the test group it writes the modified byte back to memory. When the low opcode field names a general register, the same computed byte also goes to the register file in the cycle after the memory write completes. Memory is never read a second time. A register copy therefore holds the modified value even when the target location drops the write. Flag updates are produced for the shift and test groups.

Each memory transfer is held until the memory acknowledges it, so any number of wait states is tolerated. A `start` pulse is accepted only while the block is idle.

Top module: `idxbit_seq`

## Requirements
- R1: The memory address equals the selected base plus the displacement sign-extended to 16 bits, modulo 2^16. The base is `iy_val` when `use_alt` is 1 and `ix_val` otherwise.
- R2: Each instruction makes exactly one read, followed by at most one write at the same address. `mem_req`, `mem_we` and `mem_addr` stay constant until `mem_ack`.
- R3: opcode[7:6] selects the group: 00 shift/rotate, 01 test, 10 clear, 11 set. For the shift group, opcode[5:3] selects the kind in this order: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SLL, 7 SRL. RL and RR shift `carry_in` into the vacated bit.
- R4: SLL shifts left like SLA but fills bit 0 with 1.
- R5: A shift or rotate raises `flag_we` for one cycle with `done`. `flags_out` then holds these bits: bit 0 carry (the bit shifted out), bit 2 parity (1 when the result has an even number of ones), bit 6 zero, bit 7 sign (result bit 7). Bits 1 and 4 are 0.
- R6: A test of bit n (n = opcode[5:3]) raises `flag_we` with the following flags: zero = NOT data[n]; half (bit 4) = 1; parity = zero; sign = 1 only when n = 7 and data[7] = 1; carry = `carry_in`. It writes neither memory nor a register, whatever opcode[2:0] holds.
- R7: Clear and set change only bit n (n = opcode[5:3]) of the read byte, write it back, and raise no `flag_we`.
- R8: For non-test groups, opcode[2:0] selects the register copy: 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 A. The value 110 means no copy. `rf_we` pulses with `done`; `rf_sel` = opcode[2:0]; `rf_wdata` equals the byte just written to memory.
- R9: `start` is ignored while `busy` is 1.
- R10: After reset, and after a reset in the middle of an instruction, `busy`, `done`, `mem_req`, `rf_we` and `flag_we` are 0.
- R11: `done` is a single-cycle pulse per instruction, and `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| use_alt | input | 1 | 1 selects `iy_val` as base |
| ix_val | input | 16 | First index base |
| iy_val | input | 16 | Alternate index base |
| disp | input | 8 | Signed displacement |
| opcode | input | 8 | Final opcode byte |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction finished (one cycle) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer complete |
| rf_we | output | 1 | Register copy strobe |
| rf_sel | output | 3 | Register select |
| rf_wdata | output | 8 | Register copy data |
| flag_we | output | 1 | Flag update strobe |
| flags_out | output | 8 | Flag byte (S Z - H - P N C) |

## Verification
The embedded assertions check several rules on every cycle:
- a pending memory request holds its address and direction until it is acknowledged;
- a write is only ever preceded by an acknowledged read;
- test operations never drive a write;
- a register copy is never issued for select 110, and always repeats the byte of the immediately preceding memory write;
- clear and set flip at most one bit;
- SLL always sets bit 0;
- `done` lasts one cycle.

Only the bench scenarios can show the arithmetic results:
- the exact values for each shift kind;
- the flag bytes;
- address wrap with negative and positive displacements;
- base selection;
- the single read per instruction under wait states;
- the rejected `start` during a busy instruction;
- recovery from a reset in the middle of a transfer.

// File: rtl/idxbit_pkg.sv
package idxbit_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        GRP_SHROT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SET   = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SK_RLC = 3'd0,
        SK_RRC = 3'd1,
        SK_RL  = 3'd2,
        SK_RR  = 3'd3,
        SK_SLA = 3'd4,
        SK_SRA = 3'd5,
        SK_SLL = 3'd6,
        SK_SRL = 3'd7
    } shkind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } st_e;

    localparam logic [2:0] NO_COPY = 3'b110;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] sel;
        logic [2:0] dst;
    } opf_t;

    typedef struct packed {
        logic sign;
        logic zero;
        logic rsv5;
        logic half;
        logic rsv3;
        logic parity;
        logic subtr;
        logic carry;
    } flags_t;

    function automatic opf_t split_op(input logic [7:0] op);
        opf_t f;
        f.grp = grp_e'(op[7:6]);
        f.sel = op[5:3];
        f.dst = op[2:0];
        return f;
    endfunction

    function automatic logic even_parity(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/idxbit_addr.sv
module idxbit_addr #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic              use_alt,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        base_sel = use_alt ? base_b : base_a;
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea       = base_sel + disp_ext;
    end
endmodule

// File: rtl/idxbit_alu.sv
module idxbit_alu
    import idxbit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] din,
    input  opf_t              opf,
    input  logic              cin,
    output logic [BYTE_W-1:0] res,
    output flags_t            flg
);
    logic [BYTE_W-1:0] mask;
    logic              co;
    logic              tz;

    always_comb begin
        mask = '0;
        mask[opf.sel] = 1'b1;
        res  = din;
        co   = 1'b0;
        tz   = 1'b0;
        flg  = '0;
        unique case (opf.grp)
            GRP_SHROT: begin
                unique case (shkind_e'(opf.sel))
                    SK_RLC: begin res = {din[6:0], din[7]}; co = din[7]; end
                    SK_RRC: begin res = {din[0], din[7:1]}; co = din[0]; end
                    SK_RL:  begin res = {din[6:0], cin};    co = din[7]; end
                    SK_RR:  begin res = {cin, din[7:1]};    co = din[0]; end
                    SK_SLA: begin res = {din[6:0], 1'b0};   co = din[7]; end
                    SK_SRA: begin res = {din[7], din[7:1]}; co = din[0]; end
                    SK_SLL: begin res = {din[6:0], 1'b1};   co = din[7]; end
                    SK_SRL: begin res = {1'b0, din[7:1]};   co = din[0]; end
                    default: begin res = din; co = 1'b0; end
                endcase
                flg.sign   = res[BYTE_W-1];
                flg.zero   = (res == '0);
                flg.parity = even_parity(res);
                flg.carry  = co;
            end
            GRP_TEST: begin
                tz         = ~|(din & mask);
                flg.zero   = tz;
                flg.parity = tz;
                flg.half   = 1'b1;
                flg.sign   = din[BYTE_W-1] & mask[BYTE_W-1];
                flg.carry  = cin;
            end
            GRP_CLR: res = din & ~mask;
            GRP_SET: res = din | mask;
            default: res = din;
        endcase
    end

    AST_ONE_BIT_TOUCH: assert property (@(posedge clk) disable iff (rst)
        (opf.grp == GRP_CLR || opf.grp == GRP_SET) |-> ($countones(res ^ din) <= 1)); // R7

    AST_SLL_FILL: assert property (@(posedge clk) disable iff (rst)
        (opf.grp == GRP_SHROT && opf.sel == 3'd6) |-> res[0]); // R4
endmodule

// File: rtl/idxbit_ctrl.sv
module idxbit_ctrl
    import idxbit_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ea_in,
    input  logic [7:0]        op_in,
    input  logic              cin_in,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output opf_t              opf_q,
    output logic              cin_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BYTE_W-1:0] data_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic              rf_we,
    output logic              flag_we
);
    st_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            opf_q  <= '0;
            cin_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    opf_q  <= split_op(op_in);
                    cin_q  <= cin_in;
                    addr_q <= ea_in;
                    state  <= ST_READ;
                end
                ST_READ: if (mem_ack) begin
                    data_q <= mem_rdata;
                    state  <= (opf_q.grp == GRP_TEST) ? ST_FIN : ST_WRITE;
                end
                ST_WRITE: if (mem_ack) state <= ST_FIN;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req = (state == ST_READ) || (state == ST_WRITE);
        mem_we  = (state == ST_WRITE);
        busy    = (state != ST_IDLE);
        done    = (state == ST_FIN);
        rf_we   = done && (opf_q.grp != GRP_TEST) && (opf_q.dst != NO_COPY);
        flag_we = done && ((opf_q.grp == GRP_SHROT) || (opf_q.grp == GRP_TEST));
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && mem_we == $past(mem_we) && $stable(addr_q))); // R2

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack)); // R2

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (opf_q.grp != GRP_TEST)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R11

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(opf_q)); // R9
endmodule

// File: rtl/idxbit_seq.sv
module idxbit_seq
    import idxbit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              use_alt,
    input  logic [ADDR_W-1:0] ix_val,
    input  logic [ADDR_W-1:0] iy_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [7:0]        opcode,
    input  logic              carry_in,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              rf_we,
    output logic [2:0]        rf_sel,
    output logic [BYTE_W-1:0] rf_wdata,
    output logic              flag_we,
    output logic [7:0]        flags_out
);
    logic [ADDR_W-1:0] ea;
    opf_t              opf_q;
    logic              cin_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] alu_res;
    flags_t            alu_flg;

    idxbit_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
        .use_alt (use_alt),
        .base_a  (ix_val),
        .base_b  (iy_val),
        .disp    (disp),
        .ea      (ea)
    );

    idxbit_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ea_in     (ea),
        .op_in     (opcode),
        .cin_in    (carry_in),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .opf_q     (opf_q),
        .cin_q     (cin_q),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done),
        .rf_we     (rf_we),
        .flag_we   (flag_we)
    );

    idxbit_alu u_alu (
        .clk  (clk),
        .rst  (rst),
        .din  (data_q),
        .opf  (opf_q),
        .cin  (cin_q),
        .res  (alu_res),
        .flg  (alu_flg)
    );

    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = alu_res;
        rf_sel    = opf_q.dst;
        rf_wdata  = alu_res;
        flags_out = alu_flg;
    end

    AST_RF_MATCH: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> ($past(mem_we && mem_ack) && rf_wdata == $past(mem_wdata))); // R8

    AST_RF_NO_COPY: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_sel != NO_COPY)); // R8

    AST_FLAGS_AT_END: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> done); // R5
endmodule

// File: tb/idxbit_seq_tb.sv
module idxbit_seq_tb_top;

    typedef struct packed {
        logic        alt;
        logic [15:0] ix;
        logic [15:0] iy;
        logic [7:0]  d;
        logic [7:0]  op;
        logic        cin;
        logic [7:0]  rd;
        logic [1:0]  wt;
        logic [15:0] eaddr;
        logic [7:0]  eres;
        logic [7:0]  eflg;
        logic        ewr;
        logic        erf;
        logic        efl;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1000, 16'h0000, 8'h01, 8'h00, 1'b0, 8'h81, 2'd0, 16'h1001, 8'h03, 8'h05, 1'b1, 1'b1, 1'b1},
        '{1'b1, 16'h3333, 16'h2000, 8'hFF, 8'h0F, 1'b0, 8'h01, 2'd2, 16'h1FFF, 8'h80, 8'h81, 1'b1, 1'b1, 1'b1},
        '{1'b0, 16'hFFF0, 16'h0000, 8'h20, 8'h16, 1'b1, 8'h00, 2'd0, 16'h0010, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1},
        '{1'b0, 16'h0005, 16'h0000, 8'h80, 8'h1A, 1'b0, 8'h01, 2'd1, 16'hFF85, 8'h00, 8'h45, 1'b1, 1'b1, 1'b1},
        '{1'b0, 16'h4000, 16'h0000, 8'h7F, 8'h23, 1'b1, 8'hC0, 2'd0, 16'h407F, 8'h80, 8'h81, 1'b1, 1'b1, 1'b1},
        '{1'b1, 16'h0000, 16'h1234, 8'h00, 8'h2C, 1'b0, 8'h85, 2'd0, 16'h1234, 8'hC2, 8'h81, 1'b1, 1'b1, 1'b1},
        '{1'b0, 16'h0100, 16'h0000, 8'h02, 8'h35, 1'b0, 8'h80, 2'd3, 16'h0102, 8'h01, 8'h01, 1'b1, 1'b1, 1'b1},
        '{1'b0, 16'h0200, 16'h0000, 8'hFE, 8'h31, 1'b1, 8'h7F, 2'd0, 16'h01FE, 8'hFF, 8'h84, 1'b1, 1'b1, 1'b1},
        '{1'b0, 16'h0300, 16'h0000, 8'h03, 8'h3F, 1'b0, 8'h01, 2'd0, 16'h0303, 8'h00, 8'h45, 1'b1, 1'b1, 1'b1},
        '{1'b0, 16'h0400, 16'h0000, 8'h04, 8'h40, 1'b1, 8'hFE, 2'd1, 16'h0404, 8'h00, 8'h55, 1'b0, 1'b0, 1'b1},
        '{1'b1, 16'h0000, 16'h0500, 8'h05, 8'h7F, 1'b0, 8'h80, 2'd0, 16'h0505, 8'h00, 8'h90, 1'b0, 1'b0, 1'b1},
        '{1'b0, 16'h0600, 16'h0000, 8'h06, 8'h9A, 1'b0, 8'hFF, 2'd0, 16'h0606, 8'hF7, 8'h00, 1'b1, 1'b1, 1'b0},
        '{1'b0, 16'h0700, 16'h0000, 8'h07, 8'hF6, 1'b0, 8'h00, 2'd2, 16'h0707, 8'h40, 8'h00, 1'b1, 1'b0, 1'b0},
        '{1'b1, 16'h0000, 16'h8000, 8'h10, 8'hC3, 1'b0, 8'h10, 2'd0, 16'h8010, 8'h11, 8'h00, 1'b1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        use_alt = 1'b0;
    logic [15:0] ix_val = '0;
    logic [15:0] iy_val = '0;
    logic [7:0]  disp = '0;
    logic [7:0]  opcode = '0;
    logic        carry_in = 1'b0;
    logic        busy, done, mem_req, mem_we, mem_ack, rf_we, flag_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, rf_wdata, flags_out;
    logic [7:0]  rom_byte = '0;
    logic [2:0]  rf_sel;

    int total = 0;
    int bad = 0;
    int wait_n = 0;
    int req_cnt = 0;
    int rd_cnt, wr_cnt, rf_cnt, fl_cnt, done_cnt;
    logic [15:0] rd_addr, wr_addr;
    logic [7:0]  wr_data, rf_data, fl_data;
    logic [2:0]  rf_sel_q;

    always #2 clk = ~clk;

    idxbit_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .use_alt(use_alt),
        .ix_val(ix_val), .iy_val(iy_val), .disp(disp), .opcode(opcode),
        .carry_in(carry_in), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(rom_byte), .mem_ack(mem_ack), .rf_we(rf_we),
        .rf_sel(rf_sel), .rf_wdata(rf_wdata), .flag_we(flag_we),
        .flags_out(flags_out)
    );

    assign mem_ack = mem_req && (req_cnt >= wait_n);

    always @(posedge clk) begin
        if (mem_req && !mem_ack) req_cnt <= req_cnt + 1;
        else                     req_cnt <= 0;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                wr_cnt++; wr_addr = mem_addr; wr_data = mem_wdata;
            end else begin
                rd_cnt++; rd_addr = mem_addr;
            end
        end
        if (rf_we)   begin rf_cnt++; rf_sel_q = rf_sel; rf_data = rf_wdata; end
        if (flag_we) begin fl_cnt++; fl_data = flags_out; end
        if (done)    done_cnt++;
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic clear_log();
        rd_cnt = 0; wr_cnt = 0; rf_cnt = 0; fl_cnt = 0; done_cnt = 0;
    endtask

    task automatic run_op(input vec_t v);
        @(negedge clk);
        clear_log();
        use_alt = v.alt; ix_val = v.ix; iy_val = v.iy; disp = v.d;
        opcode = v.op; carry_in = v.cin; rom_byte = v.rd; wait_n = int'(v.wt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 60 && done_cnt == 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t v;
        clear_log();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10", "busy", int'(busy), 0);
        check("R10", "mem_req", int'(mem_req), 0);
        check("R10", "done", int'(done), 0);
        check("R10", "rf_we", int'(rf_we), 0);
        check("R10", "flag_we", int'(flag_we), 0);

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            run_op(v);
            check("R1", "read addr", int'(rd_addr), int'(v.eaddr));
            check("R2", "read count", rd_cnt, 1);
            check("R2", "write count", wr_cnt, int'(v.ewr));
            if (v.ewr) begin
                check("R2", "write addr", int'(wr_addr), int'(v.eaddr));
                check("R3", "write data", int'(wr_data), int'(v.eres));
            end
            check("R8", "rf count", rf_cnt, int'(v.erf));
            if (v.erf) begin
                check("R8", "rf sel", int'(rf_sel_q), int'(v.op[2:0]));
                check("R8", "rf data", int'(rf_data), int'(v.eres));
            end
            check(v.op[7:6] == 2'b01 ? "R6" : (v.op[7] ? "R7" : "R5"),
                  "flag strobes", fl_cnt, int'(v.efl));
            if (v.efl) check(v.op[6] ? "R6" : "R5", "flags", int'(fl_data), int'(v.eflg));
            check("R11", "done pulses", done_cnt, 1);
            check("R11", "idle after", int'(busy), 0);
        end

        // R4 explicit: SLL on zero yields 0x01
        v = VECS[6]; v.rd = 8'h00; v.eres = 8'h01;
        run_op(v);
        check("R4", "sll fill", int'(wr_data), 8'h01);

        // R9: start during busy is ignored
        @(negedge clk);
        clear_log();
        use_alt = 1'b0; ix_val = 16'h0A00; disp = 8'h01; opcode = 8'hC7;
        carry_in = 1'b0; rom_byte = 8'h00; wait_n = 3;
        start = 1'b1;
        @(negedge clk);
        ix_val = 16'h0B00; opcode = 8'h80;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 60 && done_cnt == 0; k++) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R9", "reads", rd_cnt, 1);
        check("R9", "write data", int'(wr_data), 8'h01);
        check("R9", "write addr", int'(wr_addr), 16'h0A01);
        check("R9", "rf sel", int'(rf_sel_q), 7);

        // R10: reset mid-instruction
        @(negedge clk);
        clear_log();
        opcode = 8'hC0; wait_n = 3; rom_byte = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10", "req after reset", int'(mem_req), 0);
        check("R10", "busy after reset", int'(busy), 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check("R10", "no write", wr_cnt, 0);
        check("R10", "no done", done_cnt, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule